// File: doc/BRIEF.md
# Mode-Sequenced SEC-DED Memory Word Controller

This block sits between a memory bus and a single-error-correcting, double-error-detecting code over 32 data bits and 7 check bits. A two-bit mode input picks one of four operations. In write mode the block encodes the data and drives the check word. In read-and-flag mode it reports the error status live. In correct mode it works on a frozen copy of both words: it drives the repaired data and puts the syndrome on the check port. In diagnostic mode the check word is frozen and the data path stays open, so that test words can be applied against a known check word. Each bidirectional port is split into an input, an output and a drive-enable.

The input latches are registers sampled on the rising clock edge. Their capture enable comes from the mode alone. While a latch is open, the datapath uses the live input. Once it closes, the datapath uses the value sampled at the last edge before the mode changed. Both error flags are active low. Reset is asynchronous and active low, and the system is expected to release it synchronously to the clock.

Top module: `edac_mode_ctrl`

## Requirements
- R1: Write mode (mode_sel = 2'b00) keeps err_n and merr_n high and never drives the data port. The check port carries the check word generated from data_in.
- R2: Data bit j takes part in exactly three check bits. Its column is the j-th smallest 7-bit value with three ones: bit 0 is 7'h07, bit 1 is 7'h0B, bit 31 is 7'h62. Check bit r is the XOR of the data bits whose column has bit r set, so data 1 gives 7'h07 and data 3 gives 7'h0C.
- R3: The syndrome is the stored check word XOR the check word generated from the data. In read-and-flag mode (2'b10) err_n is low when the syndrome is nonzero. merr_n is low when the syndrome is nonzero and is neither one-hot nor a data column. merr_n is never low while err_n is high.
- R4: The data and check words applied in the last cycle before correct mode (2'b11) are the ones used during correct mode. Changes on data_in or chk_in while the mode stays 2'b11 have no effect on any output.
- R5: In correct mode a syndrome equal to column j inverts data bit j on data_out. A one-hot syndrome leaves the data unchanged. The check port carries the syndrome.
- R6: With two bits in error, merr_n is low and data_out passes the latched data through unchanged.
- R7: Diagnostic mode (2'b01) freezes the check word and leaves the data path open. Flags are computed for each applied data word against the frozen check word. With chk_oe_n low, the frozen check word is driven on the check port. When the block enters diagnostic mode from write mode, the frozen word is the check word generated for the last written data.
- R8: Moving from diagnostic mode to correct mode corrects the last diagnostic data word and drives its syndrome.
- R9: chk_drive is high only when chk_oe_n is low and the mode is not read-and-flag. data_drive is high only in correct mode with data_oe_n low.
- R10: While reset is asserted, both latches hold zero. In correct mode this gives data_out 0, chk_out 0 and both flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 00 write, 01 diagnostic, 10 read-and-flag, 11 correct |
| data_oe_n | input | 1 | Active-low enable for driving the data port |
| chk_oe_n | input | 1 | Active-low enable for driving the check port |
| data_in | input | 32 | Data word arriving from the bus |
| data_out | output | 32 | Corrected data word |
| data_drive | output | 1 | Data port drive-enable |
| chk_in | input | 7 | Check word arriving from the bus |
| chk_out | output | 7 | Generated check word, frozen check word or syndrome, depending on the mode |
| chk_drive | output | 1 | Check port drive-enable |
| err_n | output | 1 | Low when any error is seen |
| merr_n | output | 1 | Low when an uncorrectable error is seen |

## Verification
Two functions can fall in the same cycle: the latch closes as correct mode begins, and the bus changes at that same moment. The bench provokes this by replacing data_in and chk_in with inverted garbage in the very cycle the mode becomes 2'b11. It then judges data_out, chk_out and the flags against the word from the previous cycle. The same kind of overlap occurs in diagnostic mode, where the frozen check word is driven out while the flags follow a new data word. The reference model checks both outputs in that same cycle.

// File: rtl/edac_pkg.sv
package edac_pkg;

  localparam int DATA_W_DEF = 32;
  localparam int CHK_W_DEF  = 7;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_DIAG  = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CORR  = 2'b11
  } edac_mode_e;

  // j-th smallest value of width cw with exactly three ones
  function automatic logic [15:0] col_code(input int j, input int cw);
    int n;
    int ones;
    logic [15:0] v;
    logic [15:0] res;
    n   = 0;
    res = '0;
    for (int k = 1; k < (1 << cw); k++) begin
      v    = 16'(k);
      ones = 0;
      for (int b = 0; b < 16; b++) begin
        if (v[b]) ones++;
      end
      if (ones == 3) begin
        if (n == j) res = v;
        n++;
      end
    end
    return res;
  endfunction

  // data bits participating in check bit r
  function automatic logic [63:0] row_mask(input int r, input int dw, input int cw);
    logic [63:0] m;
    logic [15:0] c;
    m = '0;
    for (int j = 0; j < dw; j++) begin
      c    = col_code(j, cw);
      m[j] = c[r];
    end
    return m;
  endfunction

endpackage

// File: rtl/edac_checkgen.sv
module edac_checkgen #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  import edac_pkg::*;

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = DATA_W'(row_mask(r, DATA_W, CHK_W));
    assign chk[r] = ^(data & MASK);
  end

endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7
) (
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] flip,
  output logic              any_err,
  output logic              multi_err
);
  import edac_pkg::*;

  for (genvar j = 0; j < DATA_W; j++) begin : g_col
    localparam logic [CHK_W-1:0] COL = CHK_W'(col_code(j, CHK_W));
    assign flip[j] = (syn == COL);
  end

  logic chk_bit_err;
  logic correctable;

  always_comb begin
    chk_bit_err = $onehot(syn);
    correctable = chk_bit_err || (|flip);
    any_err     = |syn;
    multi_err   = any_err && !correctable;
  end

endmodule

// File: rtl/edac_in_latch.sv
module edac_in_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] eff
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (open_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  // transparent while open, frozen otherwise
  assign eff = open_en ? d : q_r;

endmodule

// File: rtl/edac_mode_ctrl.sv
module edac_mode_ctrl #(
  parameter int DATA_W = edac_pkg::DATA_W_DEF,
  parameter int CHK_W  = edac_pkg::CHK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              data_oe_n,
  input  logic              chk_oe_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_drive,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [CHK_W-1:0]  chk_out,
  output logic              chk_drive,
  output logic              err_n,
  output logic              merr_n
);
  import edac_pkg::*;

  edac_mode_e        mode;
  logic              open_d;
  logic              open_c;
  logic [DATA_W-1:0] eff_d;
  logic [CHK_W-1:0]  eff_c;
  logic [CHK_W-1:0]  chk_src;
  logic [CHK_W-1:0]  gen_chk;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              any_err;
  logic              multi_err;

  assign mode   = edac_mode_e'(mode_sel);
  assign open_d = (mode != MODE_CORR);
  assign open_c = (mode == MODE_WRITE) || (mode == MODE_READ);
  // in write mode the check latch tracks the locally generated word
  assign chk_src = (mode == MODE_WRITE) ? gen_chk : chk_in;

  edac_in_latch #(.W(DATA_W)) u_dlat (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_en (open_d),
    .d       (data_in),
    .eff     (eff_d)
  );

  edac_in_latch #(.W(CHK_W)) u_clat (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_en (open_c),
    .d       (chk_src),
    .eff     (eff_c)
  );

  edac_checkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_gen (
    .data (eff_d),
    .chk  (gen_chk)
  );

  assign syn = eff_c ^ gen_chk;

  edac_syn_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .syn       (syn),
    .flip      (flip),
    .any_err   (any_err),
    .multi_err (multi_err)
  );

  always_comb begin
    data_out   = eff_d ^ flip;
    data_drive = 1'b0;
    chk_out    = gen_chk;
    chk_drive  = 1'b0;
    err_n      = 1'b1;
    merr_n     = 1'b1;
    unique case (mode)
      MODE_WRITE: begin
        chk_out   = gen_chk;
        chk_drive = !chk_oe_n;
      end
      MODE_DIAG: begin
        chk_out   = eff_c;
        chk_drive = !chk_oe_n;
        err_n     = !any_err;
        merr_n    = !multi_err;
      end
      MODE_READ: begin
        err_n  = !any_err;
        merr_n = !multi_err;
      end
      MODE_CORR: begin
        chk_out    = syn;
        chk_drive  = !chk_oe_n;
        data_drive = !data_oe_n;
        err_n      = !any_err;
        merr_n     = !multi_err;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/edac_mode_ctrl_chk.sv
module edac_mode_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              data_oe_n,
  input logic              chk_oe_n,
  input logic [DATA_W-1:0] data_out,
  input logic              data_drive,
  input logic [CHK_W-1:0]  chk_out,
  input logic              chk_drive,
  input logic              err_n,
  input logic              merr_n
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (err_n && merr_n && !data_drive));

  a_r3_merr_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
    !merr_n |-> !err_n);

  a_r4_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_sel == 2'b11 && $past(mode_sel) == 2'b11)
      |-> ($stable(data_out) && $stable(chk_out) && $stable(err_n) && $stable(merr_n)));

  a_r7_diag_chk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_sel == 2'b01 && $past(mode_sel) == 2'b01) |-> $stable(chk_out));

  a_r9_chk_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    chk_drive |-> (!chk_oe_n && mode_sel != 2'b10));

  a_r9_data_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> (mode_sel == 2'b11 && !data_oe_n));

endmodule

bind edac_mode_ctrl edac_mode_ctrl_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (.*);

// File: tb/edac_mode_ctrl_test.sv
module edac_mode_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 32;
  localparam int CW = 7;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          data_oe_n;
  logic          chk_oe_n;
  logic [DW-1:0] data_in;
  logic [DW-1:0] data_out;
  logic          data_drive;
  logic [CW-1:0] chk_in;
  logic [CW-1:0] chk_out;
  logic          chk_drive;
  logic          err_n;
  logic          merr_n;

  int  checks;
  int  fails;
  bit  done;
  int  colv [DW];

  logic [DW-1:0] m_dq;
  logic [CW-1:0] m_cq;

  edac_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .data_oe_n(data_oe_n),
    .chk_oe_n(chk_oe_n), .data_in(data_in), .data_out(data_out),
    .data_drive(data_drive), .chk_in(chk_in), .chk_out(chk_out),
    .chk_drive(chk_drive), .err_n(err_n), .merr_n(merr_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [CW-1:0] m_gen(input logic [DW-1:0] d);
    logic [CW-1:0] g;
    g = '0;
    for (int j = 0; j < DW; j++)
      for (int r = 0; r < CW; r++)
        if (((colv[j] >> r) & 1) == 1 && d[j]) g[r] = ~g[r];
    return g;
  endfunction

  function automatic int m_find(input logic [CW-1:0] s);
    int idx;
    idx = -1;
    for (int j = 0; j < DW; j++) if (colv[j] == int'(s)) idx = j;
    return idx;
  endfunction

  // reference latches: follow the requirements, not the design structure
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dq <= '0;
      m_cq <= '0;
    end else begin
      if (mode_sel != 2'b11) m_dq <= data_in;
      if (mode_sel == 2'b00) m_cq <= m_gen(data_in);
      else if (mode_sel == 2'b10) m_cq <= chk_in;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [DW-1:0] ed;
    logic [CW-1:0] ec;
    logic [CW-1:0] s;
    logic [DW-1:0] cd;
    int            idx;
    bit            exp_err;
    bit            exp_merr;
    string         t;
    ed = (mode_sel != 2'b11) ? data_in : m_dq;
    ec = (mode_sel == 2'b00) ? m_gen(data_in) : (mode_sel == 2'b10) ? chk_in : m_cq;
    s  = ec ^ m_gen(ed);
    idx = m_find(s);
    cd = ed;
    if (idx >= 0) cd[idx] = ~cd[idx];
    exp_err  = (s != 0);
    exp_merr = (s != 0) && !($countones(s) == 1) && (idx < 0);
    if (mode_sel == 2'b00) begin exp_err = 0; exp_merr = 0; end
    case (mode_sel)
      2'b00: t = "R1";
      2'b01: t = "R7";
      2'b10: t = "R3";
      default: t = "R5";
    endcase
    chk(t, 64'(err_n), 64'(!exp_err));
    chk(t, 64'(merr_n), 64'(!exp_merr));
    chk("R9", 64'(data_drive), 64'(mode_sel == 2'b11 && !data_oe_n));
    chk("R9", 64'(chk_drive), 64'(mode_sel != 2'b10 && !chk_oe_n));
    if (mode_sel == 2'b11 && !data_oe_n) chk(t, 64'(data_out), 64'(cd));
    if (mode_sel != 2'b10 && !chk_oe_n) begin
      if (mode_sel == 2'b00)      chk(t, 64'(chk_out), 64'(m_gen(data_in)));
      else if (mode_sel == 2'b01) chk(t, 64'(chk_out), 64'(m_cq));
      else                        chk(t, 64'(chk_out), 64'(s));
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [DW-1:0] d, input logic [CW-1:0] c,
                      input bit doen, input bit coen);
    @(negedge clk);
    mode_sel  = m;
    data_in   = d;
    chk_in    = c;
    data_oe_n = doen;
    chk_oe_n  = coen;
    #1;
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] words [5];
    int n;
    checks = 0;
    fails  = 0;
    done   = 0;
    n = 0;
    for (int v = 1; v < 128; v++)
      if ($countones(v[6:0]) == 3 && n < DW) begin colv[n] = v; n++; end
    words[0] = 32'hA5A5_1234; words[1] = 32'h0000_0000; words[2] = 32'hFFFF_FFFF;
    words[3] = 32'h1357_9BDF; words[4] = 32'h8000_0001;

    rst_n = 1'b0;
    mode_sel = 2'b11; data_in = '1; chk_in = '1; data_oe_n = 1'b0; chk_oe_n = 1'b0;
    repeat (2) begin
      step(2'b11, 32'hDEAD_BEEF, 7'h55, 0, 0);
      chk("R10", 64'(data_out), 64'h0);
      chk("R10", 64'(chk_out), 64'h0);
      chk("R10", 64'({err_n, merr_n}), 64'h3);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(2'b00, 32'h1, '0, 1, 0);          chk("R2", 64'(chk_out), 64'h07);
    step(2'b00, 32'h2, '0, 1, 0);          chk("R2", 64'(chk_out), 64'h0B);
    step(2'b00, 32'h3, '0, 1, 0);          chk("R2", 64'(chk_out), 64'h0C);
    step(2'b00, 32'h8000_0000, '0, 1, 0);  chk("R2", 64'(chk_out), 64'h62);
    step(2'b00, 32'h1, '0, 1, 1);          chk("R9", 64'(chk_drive), 64'h0);

    for (int i = 0; i < 5; i++) begin
      logic [DW-1:0] w;
      logic [CW-1:0] c;
      int k;
      int b;
      w = words[i];
      c = m_gen(w);
      k = (i * 7 + 3) % 30;
      b = i % CW;
      step(2'b00, w, 7'h2A, 1, 0);
      step(2'b10, w, c, 1, 1);
      chk("R3", 64'({err_n, merr_n}), 64'h3);

      step(2'b10, w ^ (32'h1 << k), c, 1, 1);
      chk("R3", 64'(err_n), 64'h0);
      step(2'b11, ~w, ~c, 0, 0);
      chk("R4", 64'(data_out), 64'(w));
      chk("R5", 64'(chk_out), 64'(colv[k]));
      step(2'b11, w ^ 32'h0F0F_0F0F, 7'h11, 0, 0);
      chk("R4", 64'(data_out), 64'(w));

      step(2'b10, w, c ^ (7'h1 << b), 1, 1);
      step(2'b11, 32'h0, 7'h0, 0, 0);
      chk("R5", 64'(data_out), 64'(w));
      chk("R5", 64'(chk_out), 64'(7'h1 << b));
      step(2'b11, w, c, 1, 1);
      chk("R9", 64'({data_drive, chk_drive}), 64'h0);

      step(2'b10, w ^ (32'h3 << k), c, 1, 1);
      chk("R6", 64'({err_n, merr_n}), 64'h0);
      step(2'b11, ~w, c, 0, 0);
      chk("R6", 64'(merr_n), 64'h0);
      chk("R6", 64'(data_out), 64'(w ^ (32'h3 << k)));

      step(2'b10, w ^ (32'h1 << k), c ^ (7'h1 << b), 1, 1);
      chk("R6", 64'(merr_n), 64'h0);

      step(2'b10, w, c, 1, 1);
      step(2'b01, w ^ (32'h1 << k), ~c, 1, 0);
      chk("R7", 64'(chk_out), 64'(c));
      chk("R7", 64'({err_n, merr_n}), 64'h1);
      step(2'b01, w ^ (32'h5 << k), ~c, 1, 0);
      chk("R7", 64'(merr_n), 64'h0);
      step(2'b01, w ^ (32'h1 << k), ~c, 1, 0);
      step(2'b11, 32'h0, 7'h0, 0, 0);
      chk("R8", 64'(data_out), 64'(w));
      chk("R8", 64'(chk_out), 64'(colv[k]));

      step(2'b00, w, 7'h0, 1, 0);
      step(2'b01, w, 7'h7F, 1, 0);
      chk("R7", 64'(chk_out), 64'(c));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule